// File: doc/BRIEF.md
# Store-and-Forward Frame CRC Filter

This block sits behind a line decoder on the receive side of an Ethernet port. It takes a frame as a byte stream that begins with the first byte after the start-of-frame delimiter. A valid strobe qualifies each byte, and a marker flags the final byte of the frame. Every accepted byte is written into a circular frame buffer and, in the same clock, folded into a byte-wide CRC-32 update. On the final byte the block checks the running value against the good-frame residue. It then either publishes the whole frame to the read side or discards it. A discarded frame is removed by moving the speculative write pointer back to the last committed boundary, so the data is never read a second time.

The read side delivers committed frames in arrival order as a valid/ready byte stream. The four check-sequence bytes are included, and a last flag marks the final byte. A frame that grows beyond the length limit, or that arrives while the buffer has no free space, is dropped and reported with a one-cycle error pulse.

Top module: `frame_crc_filter`

## Requirements
- R1: After reset, outValid and errPulse are low and nothing is presented at the read side.
- R2: The CRC uses generator 0x04C11DB7 and starts from all ones. Data bits enter least significant bit first. The frame check sequence is the ones' complement of the reflected CRC, sent as four bytes with the least significant byte first. A frame whose running value over data plus check sequence equals 0xC704DD7B is delivered byte for byte, check bytes included, with outLast high on its final byte only. outValid rises in the first cycle after the clock edge that took the final byte, provided the buffer was empty.
- R3: A frame with a wrong check sequence produces no output bytes and does not disturb frames before or after it.
- R4: While outValid is high and outReady is low, outData and outLast hold their values. A byte is consumed only when outValid and outReady are both high.
- R5: A frame longer than MAX_LEN bytes (check bytes counted) is dropped. errPulse is high for one cycle following the byte numbered MAX_LEN+1, and the frame's remaining bytes up to its last marker are ignored.
- R6: A byte that arrives while the buffer holds 2^ADDR_W written but unread bytes causes its frame to be dropped. errPulse rises for one cycle after that byte, and committed frames already in the buffer stay intact.
- R7: Frames may follow each other with no idle cycle. The CRC restarts for each frame.
- R8: Cycles with inValid low inside a frame are ignored, and only strobed bytes enter the buffer and the CRC.
- R9: A good frame of exactly MAX_LEN bytes is accepted without an error pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte qualifier |
| inData | input | 8 | Input frame byte |
| inLast | input | 1 | Marks the final byte of a frame |
| outReady | input | 1 | Downstream accepts the presented byte |
| outValid | output | 1 | A committed byte is presented |
| outData | output | 8 | Presented frame byte |
| outLast | output | 1 | Presented byte ends its frame |
| errPulse | output | 1 | One-cycle pulse on an overlong or overflowing frame |

## Verification
The bench builds the block with ADDR_W=5, which gives a 32-byte buffer, and MAX_LEN=20. With these values the length limit is met and exceeded by one byte using frames of only 20 and 21 bytes. A buffer overflow is reached by holding one committed 20-byte frame unread and streaming a second frame into the remaining twelve bytes. The same small buffer also makes the pointers wrap across several test frames, so the rewind and the commit are exercised at the wrap boundary.

// File: rtl/frmchk_pkg.sv
package frmchk_pkg;

  localparam logic [31:0] CRC_POLY    = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED    = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hC704DD7B;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic commit;
    logic rewind;
    logic crcRestart;
  } bufCmd_t;

  typedef enum logic {
    ST_TAKE,
    ST_SKIP
  } rxState_t;

  // one byte through the CRC in a single step, bit 0 of the byte first
  function automatic logic [31:0] crcByte(input logic [31:0] cur, input logic [7:0] dat);
    logic [31:0] r;
    r = cur;
    for (int i = 0; i < 8; i++) begin
      if (r[31] ^ dat[i]) r = (r << 1) ^ CRC_POLY;
      else                r = r << 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/frmchk_ctrl.sv
module frmchk_ctrl
  import frmchk_pkg::*;
#(
  parameter int MAX_LEN = 1600
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    inLast,
  input  logic    full,
  input  logic    crcMatch,
  output bufCmd_t cmd,
  output logic    errPulse
);
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_LEN);

  rxState_t         state, stateNxt;
  logic [LEN_W-1:0] lenCount, lenNxt;
  logic             errNxt;

  always_comb begin
    cmd      = '0;
    stateNxt = state;
    lenNxt   = lenCount;
    errNxt   = 1'b0;
    if (inValid) begin
      case (state)
        ST_TAKE: begin
          if (full || lenCount == LEN_LIMIT) begin
            // frame cannot be kept: drop what is buffered so far
            cmd.rewind     = 1'b1;
            cmd.crcRestart = 1'b1;
            errNxt         = 1'b1;
            lenNxt         = '0;
            if (!inLast) stateNxt = ST_SKIP;
          end else begin
            cmd.wrEn = 1'b1;
            if (inLast) begin
              cmd.crcRestart = 1'b1;
              lenNxt         = '0;
              if (crcMatch) cmd.commit = 1'b1;
              else          cmd.rewind = 1'b1;
            end else begin
              lenNxt = lenCount + LEN_W'(1);
            end
          end
        end
        ST_SKIP: begin
          if (inLast) stateNxt = ST_TAKE;
        end
        default: stateNxt = ST_TAKE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_TAKE;
      lenCount <= '0;
      errPulse <= 1'b0;
    end else begin
      state    <= stateNxt;
      lenCount <= lenNxt;
      errPulse <= errNxt;
    end
  end

  // length counter never passes the limit
  assert_len_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    lenCount <= LEN_LIMIT)
    else $error("frame length counter beyond limit");

endmodule

// File: rtl/frmchk_dp.sv
module frmchk_dp
  import frmchk_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  bufCmd_t    cmd,
  input  logic [7:0] inData,
  input  logic       inLast,
  output logic       full,
  output logic       crcMatch,
  input  logic       outReady,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       outLast
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  logic [8:0]       mem [DEPTH];
  logic [PTR_W-1:0] specPtr, commitPtr, rdPtr, specInc;
  logic [PTR_W-1:0] usedCnt, readyCnt;
  logic [31:0]      crcReg, crcNext;
  logic             take;

  // byte-wide CRC step, same cycle as the buffer write
  assign crcNext  = crcByte(crcReg, inData);
  assign crcMatch = (crcNext == CRC_RESIDUE);

  always_ff @(posedge clk) begin
    if (!rstN)               crcReg <= CRC_SEED;
    else if (cmd.crcRestart) crcReg <= CRC_SEED;
    else if (cmd.wrEn)       crcReg <= crcNext;
  end

  // frame store
  always_ff @(posedge clk) begin
    if (cmd.wrEn) mem[specPtr[ADDR_W-1:0]] <= {inLast, inData};
  end

  assign specInc  = specPtr + (cmd.wrEn ? PTR_W'(1) : PTR_W'(0));
  assign usedCnt  = specPtr - rdPtr;
  assign readyCnt = commitPtr - rdPtr;
  assign full     = (usedCnt == DEPTH_P);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      specPtr   <= '0;
      commitPtr <= '0;
    end else begin
      if (cmd.rewind) specPtr <= commitPtr;
      else            specPtr <= specInc;
      if (cmd.commit) commitPtr <= specInc;
    end
  end

  // read side
  assign outValid = (commitPtr != rdPtr);
  assign take     = outValid && outReady;
  assign {outLast, outData} = mem[rdPtr[ADDR_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rstN)     rdPtr <= '0;
    else if (take) rdPtr <= rdPtr + PTR_W'(1);
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    usedCnt <= DEPTH_P)
    else $error("buffer holds more than its depth");

  assert_commit_behind_R2: assert property (@(posedge clk) disable iff (!rstN)
    readyCnt <= usedCnt)
    else $error("committed pointer ahead of write pointer");

  assert_rewind_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.rewind |=> (specPtr == commitPtr))
    else $error("rewind did not restore the write pointer");

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)))
    else $error("output changed while stalled");

endmodule

// File: rtl/frame_crc_filter.sv
module frame_crc_filter
  import frmchk_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int MAX_LEN = 1600
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inData,
  input  logic       inLast,
  input  logic       outReady,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       outLast,
  output logic       errPulse
);
  bufCmd_t cmd;
  logic    full;
  logic    crcMatch;

  frmchk_ctrl #(.MAX_LEN(MAX_LEN)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .full     (full),
    .crcMatch (crcMatch),
    .cmd      (cmd),
    .errPulse (errPulse)
  );

  frmchk_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .inData   (inData),
    .inLast   (inLast),
    .full     (full),
    .crcMatch (crcMatch),
    .outReady (outReady),
    .outValid (outValid),
    .outData  (outData),
    .outLast  (outLast)
  );

endmodule

// File: tb/sim_frame_crc_filter.sv
`timescale 1ns/1ps
module sim_frame_crc_filter;
  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid, inLast, outReady;
  logic [7:0] inData;
  logic       outValid, outLast, errPulse;
  logic [7:0] outData;

  int checks = 0;
  int errors = 0;

  logic [7:0] sData [0:255];
  logic       sLast [0:255];
  int         sLen = 0;
  logic [7:0] expData [0:1023];
  logic       expLast [0:1023];
  int         wrIdx = 0;
  int         rdIdx = 0;
  int         errSeen, errAt;
  logic       postValid;

  always #2 clk = ~clk;

  frame_crc_filter #(.ADDR_W(5), .MAX_LEN(20)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inLast(inLast),
    .outReady(outReady), .outValid(outValid), .outData(outData), .outLast(outLast),
    .errPulse(errPulse)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reflected reference CRC, right-shifting form
  function automatic logic [31:0] refCrc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic addFrame(input int nPay, input int seed, input bit bad, input bit keep);
    logic [31:0] c, fcs;
    int base;
    base = sLen;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < nPay; i++) begin
      sData[base+i] = 8'((seed * 7 + i * 13 + 1) & 255);
      sLast[base+i] = 1'b0;
      c = refCrc(c, sData[base+i]);
    end
    fcs = ~c;
    for (int j = 0; j < 4; j++) begin
      sData[base+nPay+j] = fcs[8*j +: 8];
      sLast[base+nPay+j] = (j == 3);
    end
    if (bad) sData[base+1] = sData[base+1] ^ 8'h10;
    sLen = base + nPay + 4;
    if (keep) begin
      for (int i = base; i < sLen; i++) begin
        expData[wrIdx] = sData[i];
        expLast[wrIdx] = sLast[i];
        wrIdx++;
      end
    end
  endtask

  task automatic sendStream(input bit gaps);
    int lastDrv;
    errSeen = 0;
    errAt = -1;
    lastDrv = -1;
    for (int i = 0; i < sLen; i++) begin
      if (gaps && i > 0 && (i % 3) == 0) begin
        @(negedge clk);
        if (errPulse) begin errSeen++; errAt = lastDrv; end
        inValid = 1'b0;
        lastDrv = -1;
      end
      @(negedge clk);
      if (errPulse) begin errSeen++; errAt = lastDrv; end
      inValid = 1'b1;
      inData  = sData[i];
      inLast  = sLast[i];
      lastDrv = i;
    end
    @(negedge clk);
    if (errPulse) begin errSeen++; errAt = lastDrv; end
    postValid = outValid;
    inValid = 1'b0;
    inLast  = 1'b0;
    sLen = 0;
  endtask

  // mode 0: always ready, mode 1: ready two cycles of three
  task automatic drain(input int mode, input string req);
    bit   stall;
    logic [7:0] pData;
    logic pLast;
    int   idle;
    stall = 0; idle = 0; pData = '0; pLast = 1'b0;
    for (int cyc = 0; cyc < 400 && idle < 5; cyc++) begin
      @(negedge clk);
      if (stall) begin
        chk(outValid && outData == pData && outLast == pLast, "R4 hold", {23'h0, outLast, outData}, {23'h0, pLast, pData});
      end
      outReady = (mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (outValid && outReady) begin
        if (rdIdx >= wrIdx) begin
          chk(1'b0, {req, " unexpected byte"}, {24'h0, outData}, 32'h0);
        end else begin
          chk(outData == expData[rdIdx] && outLast == expLast[rdIdx], req,
              {23'h0, outLast, outData}, {23'h0, expLast[rdIdx], expData[rdIdx]});
          rdIdx++;
        end
      end
      stall = outValid && !outReady;
      pData = outData;
      pLast = outLast;
      if (rdIdx == wrIdx) idle++;
    end
    @(negedge clk);
    outReady = 1'b0;
    chk(!outValid && rdIdx == wrIdx, {req, " nothing left"}, {31'h0, outValid}, 32'h0);
  endtask

  task automatic testReset;
    chk(outValid == 1'b0, "R1 outValid after reset", {31'h0, outValid}, 32'h0);
    chk(errPulse == 1'b0, "R1 errPulse after reset", {31'h0, errPulse}, 32'h0);
  endtask

  task automatic testGood;
    addFrame(10, 1, 0, 1);
    sendStream(0);
    chk(postValid == 1'b1, "R2 outValid after last byte", {31'h0, postValid}, 32'h1);
    chk(errSeen == 0, "R2 no error", errSeen, 0);
    drain(0, "R2 good frame");
  endtask

  task automatic testBad;
    addFrame(8, 2, 1, 0);
    sendStream(0);
    chk(postValid == 1'b0, "R3 bad frame not presented", {31'h0, postValid}, 32'h0);
    drain(0, "R3 bad frame");
    addFrame(6, 3, 0, 1);
    sendStream(0);
    drain(0, "R3 good after bad");
  endtask

  task automatic testReady;
    addFrame(12, 4, 0, 1);
    sendStream(0);
    drain(1, "R4 stalled read");
  endtask

  task automatic testGaps;
    addFrame(11, 5, 0, 1);
    sendStream(1);
    chk(errSeen == 0, "R8 no error with gaps", errSeen, 0);
    drain(0, "R8 frame with gaps");
  endtask

  task automatic testBackToBack;
    addFrame(5, 6, 0, 1);
    addFrame(6, 7, 1, 0);
    addFrame(7, 8, 0, 1);
    sendStream(0);
    chk(errSeen == 0, "R7 no error", errSeen, 0);
    drain(0, "R7 back to back");
  endtask

  task automatic testExactMax;
    addFrame(16, 9, 0, 1);
    sendStream(0);
    chk(errSeen == 0, "R9 no error at limit", errSeen, 0);
    drain(0, "R9 frame at limit");
  endtask

  task automatic testOverlong;
    addFrame(17, 10, 0, 0);
    sendStream(0);
    chk(errSeen == 1, "R5 one error pulse", errSeen, 1);
    chk(errAt == 20, "R5 error after byte 21", errAt, 20);
    drain(0, "R5 overlong dropped");
    addFrame(9, 11, 0, 1);
    sendStream(0);
    drain(0, "R5 good after overlong");
  endtask

  task automatic testOverflow;
    addFrame(16, 12, 0, 1);
    sendStream(0);
    addFrame(12, 13, 0, 0);
    sendStream(0);
    chk(errSeen == 1, "R6 one error pulse", errSeen, 1);
    chk(errAt == 12, "R6 error on full buffer", errAt, 12);
    drain(1, "R6 earlier frame intact");
    addFrame(10, 14, 0, 1);
    sendStream(0);
    drain(0, "R6 good after overflow");
  endtask

  initial begin
    rstN = 1'b0; inValid = 1'b0; inData = '0; inLast = 1'b0; outReady = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGood();
    testBad();
    testReady();
    testGaps();
    testBackToBack();
    testExactMax();
    testOverlong();
    testOverflow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule